// File: doc/BRIEF.md
# Interrupt Pending and Mask Controller

This block gathers up to 64 interrupt sources into a pending vector and gates that vector with a 64-bit enable mask. Each vector is split into a high and a low 32-bit word on a small register bus. Bits are numbered MSB-first: index 0 is bit 31 of the high word, and index 63 is bit 0 of the low word.

Each source is one of two kinds, chosen by a parameter:
- A **latched** source sets its pending bit when it pulses. Software clears that bit by writing a one to it.
- A **live** source has its own event register outside this block. Its pending bit simply mirrors the level that register presents, which is the OR of its unmasked event bits. Software clears a live source by clearing those event bits, not by writing here.

Masking never stops capture. It only stops delivery to the core. The block raises a registered interrupt request whenever any pending bit is also enabled. In the same cycle it reports the index of the highest-priority active source, where a lower index wins.

Top module: `intr_pend_mask_ctrl`

## Requirements
- R1: A pulse on `src_evt[i]` for an implemented latched source sets pending bit i on the next clock edge, whatever the value of mask bit i.
- R2: Writing a word to the pending high word (address 0) or low word (address 1) clears each latched bit whose written value is 1. Bits written with 0 keep their value, and a latched bit can only become 1 through its event input.
- R3: When a pending bit is written with 1 in the same cycle that its source event arrives, the bit stays set.
- R4: A live source's pending bit reads as the current level of `evt_live[i]`. Writes to the pending register have no effect on live bits.
- R5: `irq_out` is a register that loads the OR over all i of (pending[i] AND mask[i]). A mask bit of 1 enables delivery and a mask bit of 0 blocks it.
- R6: Clearing a mask bit withdraws that source's request, so `irq_out` drops one edge later if no other enabled source is pending. Setting the mask bit again presents the still-pending request on the next edge.
- R7: Reset clears both mask words, all latched pending bits and `irq_out`. Both mask words read back their stored value at any time.
- R8: With the default parameters, the implemented high-word positions are indices 0–15 (port pins), 17–23 (external lines 1–7), 29 (timer count) and 30 (periodic timer). All low-word positions are implemented. Indices 32–47 are live sources. Every unimplemented bit reads as 0 in both the pending and the mask registers.
- R9: `top_vld` is 1 exactly when some bit is both pending and enabled. `top_idx` then gives the lowest such index. Both outputs follow the state combinationally.
- R10: The register map is: address 0 pending high, 1 pending low, 2 mask high, 3 mask low. A register word carries index 0 (high word) or index 32 (low word) in data bit 31. Read data is combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| src_evt | input | 64 | Event pulses for latched sources, index 0 first |
| evt_live | input | 64 | Levels from external event registers for live sources |
| irq_out | output | 1 | Registered interrupt request to the core |
| top_idx | output | 6 | Index of highest-priority pending and enabled source |
| top_vld | output | 1 | `top_idx` is meaningful |

## Verification
The assertions assume that `src_evt` is sampled only on clock edges and that `rst` is held for at least one edge before stimulus starts. They also assume that every rise of a latched bit is explained by an event pulse one edge earlier.

The bench drives all inputs one time unit after a rising edge. Reads sweep `reg_addr` while `reg_wr` is low, so no write can land in the middle of a read. Live levels are held steady across each edge so that the model and the design see the same value.

// File: rtl/intr_pend_mask_ctrl.sv
module intr_pend_mask_ctrl #(
  parameter logic [0:63] IMPL = 64'hFFFF_7F06_FFFF_FFFF,
  parameter logic [0:63] LIVE = 64'h0000_0000_FFFF_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [0:63] src_evt,
  input  logic [0:63] evt_live,
  output logic        irq_out,
  output logic [5:0]  top_idx,
  output logic        top_vld
);
  localparam logic [0:63] LATCHED = IMPL & ~LIVE;

  logic [0:63] lat_q, mask_q, pend_v, act_v, clr_v;
  logic        irq_q;

  assign clr_v = !reg_wr           ? '0 :
                 reg_addr == 2'd0  ? {reg_wdata, 32'b0} :
                 reg_addr == 2'd1  ? {32'b0, reg_wdata} : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      lat_q <= ((lat_q & ~clr_v) | src_evt) & LATCHED;
      if (reg_wr && reg_addr == 2'd2) mask_q[0:31]  <= reg_wdata & IMPL[0:31];
      if (reg_wr && reg_addr == 2'd3) mask_q[32:63] <= reg_wdata & IMPL[32:63];
      irq_q <= |act_v;
    end
  end

  assign pend_v  = lat_q | (evt_live & LIVE & IMPL);
  assign act_v   = pend_v & mask_q;
  assign irq_out = irq_q;

  always_comb begin
    top_idx = '0;
    top_vld = 1'b0;
    for (int i = 63; i >= 0; i--) begin
      if (act_v[i]) begin
        top_idx = 6'(i);
        top_vld = 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = pend_v[0:31];
      2'd1:    reg_rdata = pend_v[32:63];
      2'd2:    reg_rdata = mask_q[0:31];
      default: reg_rdata = mask_q[32:63];
    endcase
  end
endmodule

module intr_pend_mask_chk #(
  parameter logic [0:63] IMPL = 64'hFFFF_7F06_FFFF_FFFF,
  parameter logic [0:63] LIVE = 64'h0000_0000_FFFF_0000
) (
  input logic        clk,
  input logic        rst,
  input logic [0:63] src_evt,
  input logic [0:63] lat_q,
  input logic [0:63] mask_q,
  input logic [0:63] pend_v,
  input logic        irq_out,
  input logic [5:0]  top_idx,
  input logic        top_vld
);
  localparam logic [0:63] LATCHED = IMPL & ~LIVE;

  p_set_captured_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((lat_q & $past(src_evt & LATCHED)) == $past(src_evt & LATCHED)));

  p_rise_needs_event_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((lat_q & ~$past(lat_q) & ~$past(src_evt)) == '0));

  p_masked_no_irq_r5: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq_out);

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (rst)
    ((mask_q | pend_v) & ~IMPL) == '0);

  p_top_active_r9: assert property (@(posedge clk) disable iff (rst)
    top_vld |-> (pend_v[top_idx] && mask_q[top_idx]));

  p_top_none_r9: assert property (@(posedge clk) disable iff (rst)
    !top_vld |-> ((pend_v & mask_q) == '0));
endmodule

bind intr_pend_mask_ctrl intr_pend_mask_chk #(.IMPL(IMPL), .LIVE(LIVE)) u_chk (
  .clk(clk), .rst(rst), .src_evt(src_evt), .lat_q(lat_q), .mask_q(mask_q),
  .pend_v(pend_v), .irq_out(irq_out), .top_idx(top_idx), .top_vld(top_vld)
);

// File: tb/sim_intr_pend_mask_ctrl.sv
module sim_intr_pend_mask_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1, reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [0:63] src_evt = '0, evt_live = '0;
  logic        irq_out, top_vld;
  logic [5:0]  top_idx;

  intr_pend_mask_ctrl u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [0:63] m_lat = '0, m_mask = '0;

  function automatic logic [0:63] bitv(int i);
    logic [0:63] v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [0:63] impl_set();
    logic [0:63] v = '0;
    for (int i = 0; i < 64; i++)
      if (i <= 15 || (i >= 17 && i <= 23) || i == 29 || i == 30 || i >= 32) v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [0:63] live_set();
    logic [0:63] v = '0;
    for (int i = 32; i <= 47; i++) v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [0:63] m_pend(logic [0:63] lv);
    return m_lat | (lv & live_set() & impl_set());
  endfunction

  function automatic int m_top(logic [0:63] act);
    for (int i = 0; i < 64; i++) if (act[i]) return i;
    return -1;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic verify(string tag);
    logic [0:63] p = m_pend(evt_live);
    logic [0:63] a = p & m_mask;
    int t = m_top(a);
    reg_addr = 2'd0; #1; chk({tag, " R10 R1 R2 R4 pend_hi"}, 64'(reg_rdata), 64'(p[0:31]));
    reg_addr = 2'd1; #1; chk({tag, " R10 R1 R2 R4 pend_lo"}, 64'(reg_rdata), 64'(p[32:63]));
    reg_addr = 2'd2; #1; chk({tag, " R7 R8 mask_hi"}, 64'(reg_rdata), 64'(m_mask[0:31]));
    reg_addr = 2'd3; #1; chk({tag, " R7 R8 mask_lo"}, 64'(reg_rdata), 64'(m_mask[32:63]));
    chk({tag, " R9 top_vld"}, 64'(top_vld), 64'(t >= 0));
    if (t >= 0) chk({tag, " R9 top_idx"}, 64'(top_idx), 64'(t));
  endtask

  task automatic step(string tag, bit wr, logic [1:0] a, logic [31:0] d,
                      logic [0:63] ev, logic [0:63] lv);
    logic irq_exp;
    logic [0:63] w1c;
    reg_wr = wr; reg_addr = a; reg_wdata = d; src_evt = ev; evt_live = lv;
    irq_exp = |(m_pend(lv) & m_mask);
    @(posedge clk); #1;
    w1c = !wr ? '0 : a == 2'd0 ? {d, 32'b0} : a == 2'd1 ? {32'b0, d} : '0;
    m_lat = ((m_lat & ~w1c) | ev) & impl_set() & ~live_set();
    if (wr && a == 2'd2) m_mask[0:31]  = d & impl_set()[0:31];
    if (wr && a == 2'd3) m_mask[32:63] = d & impl_set()[32:63];
    reg_wr = 0; src_evt = '0;
    chk({tag, " R5 R6 irq_out"}, 64'(irq_out), 64'(irq_exp));
    verify(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [0:63] lv;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    chk("R7 reset irq", 64'(irq_out), 64'd0);
    verify("R7 reset");

    step("R8 mask_hi all ones", 1, 2'd2, 32'hFFFF_FFFF, '0, '0);
    step("R8 mask_lo all ones", 1, 2'd3, 32'hFFFF_FFFF, '0, '0);
    step("R1 evt idx3", 0, 0, 0, bitv(3), '0);
    chk("R9 idx3 top", 64'(top_idx), 64'd3);
    step("R5 irq after evt", 0, 0, 0, '0, '0);
    chk("R5 irq raised", 64'(irq_out), 64'd1);
    step("R8 reserved evt16", 0, 0, 0, bitv(16), '0);
    step("R2 write zero", 1, 2'd0, 32'h0, '0, '0);
    step("R3 set wins", 1, 2'd0, 32'h1000_0000, bitv(3), '0);
    reg_addr = 2'd0; #1;
    chk("R3 idx3 still pending", 64'(reg_rdata[28]), 64'd1);
    step("R2 w1c idx3", 1, 2'd0, 32'h1000_0000, '0, '0);
    reg_addr = 2'd0; #1;
    chk("R2 idx3 cleared", 64'(reg_rdata[28]), 64'd0);
    step("R1 masked evt50", 1, 2'd3, 32'h0, bitv(50), '0);
    step("R6 mask off hi", 1, 2'd2, 32'h0, bitv(5), '0);
    step("R6 idle", 0, 0, 0, '0, '0);
    chk("R6 withdrawn", 64'(irq_out), 64'd0);
    step("R6 re-enable lo", 1, 2'd3, 32'h0000_2000, '0, '0);
    step("R6 idle2", 0, 0, 0, '0, '0);
    chk("R6 presented", 64'(irq_out), 64'd1);
    chk("R9 idx50 top", 64'(top_idx), 64'd50);
    lv = bitv(33);
    step("R4 live on", 1, 2'd3, 32'h4000_0000, '0, lv);
    step("R4 live write ignored", 1, 2'd1, 32'hFFFF_FFFF, '0, lv);
    reg_addr = 2'd1; #1;
    chk("R4 live bit reads 1", 64'(reg_rdata[30]), 64'd1);
    step("R4 live off", 0, 0, 0, '0, '0);

    for (int n = 0; n < 600; n++) begin
      logic [0:63] ev;
      logic [31:0] d;
      ev = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
      if (n % 8 == 0) lv = {$urandom, $urandom & $urandom};
      d = ($urandom % 3 == 0) ? $urandom : $urandom & $urandom;
      step("R1 R2 R3 rand", ($urandom % 2) == 1, 2'($urandom), d, ev, lv);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule